// File: doc/BRIEF.md
# Nonvolatile Program Store Bus Front End

This block is the bus-side front end of an embedded nonvolatile program store of 16-bit words. The storage is modelled as an inferred RAM whose depth is set by `ADDR_W`. The full device uses `ADDR_W = 14`, which gives 16384 words. The default is smaller so that the block stays cheap to elaborate. A processor reaches the block through two paths: a memory-space port that covers the whole decoded window of the store, and an I/O-space port.

One I/O address, `MODE_IO_ADDR` (default 0xFF0F), acts as a mode switch. The direction of the I/O cycle selects the mode, and no data is carried. An I/O write to that address selects register view. An I/O read from it selects array view.

In array view, memory reads return stored words with a fixed latency of one clock and no wait states. In register view, the array is hidden. Four control registers then repeat every four words across the window. Through these registers software starts a whole-array erase, which sets every bit to 1, or a single-word program, which can only clear bits. Software also reads a busy flag from them.

Top module: `nvs_front`

## Requirements
- R1: After reset the block is in array view, `memRData` is 0x0000, and all four control registers read 0x0000.
- R2: An I/O write (`ioEn`=1, `ioWe`=1) to `MODE_IO_ADDR` selects register view from the next cycle. An I/O access to any other address changes nothing.
- R3: An I/O read (`ioEn`=1, `ioWe`=0) to `MODE_IO_ADDR` selects array view from the next cycle. An I/O read to any other address changes nothing.
- R4: In register view, `memAddr[1:0]` selects a register at every address in the window: 0 is command, 1 is target address, 2 is program data, and 3 is status. Array words can be neither read nor altered in this view.
- R5: Writing the command register with bit 0 set starts an erase. This holds even when bit 1 is also set, because erase takes priority. The erase sets every word to 0xFFFF, one word per cycle, and status bit 0 reads 1 for exactly 2^ADDR_W cycles. The command then reads 0x0000 again.
- R6: Writing the command register with only bit 1 set programs word `target[ADDR_W-1:0]` to (old AND data). Programming never turns a 0 bit into a 1. Status reads busy for exactly the one cycle after the command.
- R7: While busy, array-view reads return 0xFFFF and command register writes are ignored.
- R8: An array-view read presented in cycle n appears on `memRData` after the clock edge that ends cycle n. Reads may be issued back to back, one per cycle.
- R9: Memory writes in array view leave the array unchanged.
- R10: Status reads as {15'b0, busy}, and writes to it are ignored. Command register bits 15:2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memEn | input | 1 | Memory-space access in the store's window |
| memWe | input | 1 | 1 = write, 0 = read for the memory access |
| memAddr | input | ADDR_W | Word address within the window |
| memWData | input | 16 | Memory write data |
| memRData | output | 16 | Read data, registered, held between reads |
| ioEn | input | 1 | I/O-space access strobe |
| ioWe | input | 1 | 1 = I/O write, 0 = I/O read |
| ioAddr | input | 16 | I/O address |

## Verification
A wrong mode bit shows up on the very next memory read: array words appear where register values were expected, or the reverse. A stuck or mis-sequenced command bit shows up as a wrong count of busy cycles when status is polled every cycle. It can also show as an array word that is not 0xFFFF after an erase, or not old AND data after a program. A fault in the erase counter or in the program write path stays hidden until the affected word is read back. For that reason, every erase and every program sweep is followed by a full readback against a word-by-word model in the bench.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_TGT  = 2'd1,
    SEL_DAT  = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic arrWr;     // write one array word this cycle
    logic progMode;  // 1 = AND with data, 0 = erase to all ones
    logic arrRd;     // array-view read this cycle
    logic regRd;     // register-view read this cycle
    logic busy;      // an operation is in progress
  } nvsStrobe_t;

endpackage

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [15:0] MODE_IO_ADDR = 16'hFF0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [1:0]        regSelIn,
  input  logic [WORD_W-1:0] memWData,
  input  logic              ioEn,
  input  logic              ioWe,
  input  logic [15:0]       ioAddr,
  output nvsStrobe_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] progData,
  output logic [WORD_W-1:0] regRdVal
);

  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  logic              regMode;
  logic [1:0]        cmdReg;
  logic [WORD_W-1:0] tgtReg;
  logic [WORD_W-1:0] datReg;
  logic [ADDR_W-1:0] sweepCnt;

  logic    ioHit, busy, erasing, programming, regWr, cmdWr;
  regSel_e sel;

  assign ioHit       = ioEn && (ioAddr == MODE_IO_ADDR);
  assign sel         = regSel_e'(regSelIn);
  assign busy        = |cmdReg;
  assign erasing     = cmdReg[0];
  assign programming = cmdReg[1] && !cmdReg[0];
  assign regWr       = memEn && memWe && regMode;
  assign cmdWr       = regWr && (sel == SEL_CMD) && !busy;

  // Mode state: direction of the I/O cycle picks the view
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      regMode <= 1'b0;
    else if (ioHit) regMode <= ioWe;
  end

  // Command register with self-clearing bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= 2'b00;
    end else if (cmdWr) begin
      if (memWData[0])      cmdReg <= 2'b01;
      else if (memWData[1]) cmdReg <= 2'b10;
      else                  cmdReg <= 2'b00;
    end else if (erasing && sweepCnt == LAST_IDX) begin
      cmdReg <= 2'b00;
    end else if (programming) begin
      cmdReg <= 2'b00;
    end
  end

  // Erase sweep counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        sweepCnt <= '0;
    else if (cmdWr)   sweepCnt <= '0;
    else if (erasing) sweepCnt <= sweepCnt + 1'b1;
  end

  // Target and data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tgtReg <= '0;
      datReg <= '0;
    end else if (regWr) begin
      if (sel == SEL_TGT) tgtReg <= memWData;
      if (sel == SEL_DAT) datReg <= memWData;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CMD:  regRdVal = {{(WORD_W-2){1'b0}}, cmdReg};
      SEL_TGT:  regRdVal = tgtReg;
      SEL_DAT:  regRdVal = datReg;
      default:  regRdVal = {{(WORD_W-1){1'b0}}, busy};
    endcase
  end

  assign strb.arrWr    = erasing || programming;
  assign strb.progMode = programming;
  assign strb.arrRd    = memEn && !memWe && !regMode;
  assign strb.regRd    = memEn && !memWe && regMode;
  assign strb.busy     = busy;
  assign wrAddr        = erasing ? sweepCnt : tgtReg[ADDR_W-1:0];
  assign progData      = datReg;

  // R2
  mode_enter_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioHit && ioWe) |=> regMode);

  // R3
  mode_leave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioHit && !ioWe) |=> !regMode);

  // R6
  prog_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    programming |=> !programming);

  // R5 R7
  erase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (erasing && sweepCnt != LAST_IDX) |=> $stable(cmdReg));

endmodule

// File: rtl/nvs_datapath.sv
module nvs_datapath
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvsStrobe_t        strb,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] progData,
  input  logic [WORD_W-1:0] regRdVal,
  output logic [WORD_W-1:0] rdData
);

  localparam int WORDS = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] oldWord;
  logic [WORD_W-1:0] newWord;

  assign oldWord = mem[wrAddr];
  assign newWord = strb.progMode ? (oldWord & progData) : '1;

  always_ff @(posedge clk) begin
    if (strb.arrWr) mem[wrAddr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (strb.regRd) rdData <= regRdVal;
    else if (strb.arrRd) rdData <= strb.busy ? '1 : mem[memAddr];
  end

  // Checker state for the program path
  logic              chkPend;
  logic [ADDR_W-1:0] chkAddr;
  logic [WORD_W-1:0] chkOld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkPend <= 1'b0;
    else       chkPend <= strb.arrWr && strb.progMode;
  end

  always_ff @(posedge clk) begin
    chkAddr <= wrAddr;
    chkOld  <= oldWord;
  end

  // R6
  always_ff @(posedge clk) begin
    if (rstN && chkPend)
      prog_no_set_chk: assert ((mem[chkAddr] & ~chkOld) == '0);
  end

  // R7
  busy_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.arrRd && strb.busy && !strb.regRd) |=> (rdData == 16'hFFFF));

endmodule

// File: rtl/nvs_front.sv
module nvs_front
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter logic [15:0] MODE_IO_ADDR = 16'hFF0F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memEn,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [15:0]       memWData,
  output logic [15:0]       memRData,
  input  logic              ioEn,
  input  logic              ioWe,
  input  logic [15:0]       ioAddr
);

  nvsStrobe_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [WORD_W-1:0] progData;
  logic [WORD_W-1:0] regRdVal;

  nvs_ctrl #(.ADDR_W(ADDR_W), .MODE_IO_ADDR(MODE_IO_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .memEn    (memEn),
    .memWe    (memWe),
    .regSelIn (memAddr[1:0]),
    .memWData (memWData),
    .ioEn     (ioEn),
    .ioWe     (ioWe),
    .ioAddr   (ioAddr),
    .strb     (strb),
    .wrAddr   (wrAddr),
    .progData (progData),
    .regRdVal (regRdVal)
  );

  nvs_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memAddr  (memAddr),
    .wrAddr   (wrAddr),
    .progData (progData),
    .regRdVal (regRdVal),
    .rdData   (memRData)
  );

endmodule

// File: tb/test_nvs_front.sv
module test_nvs_front;

  localparam int AW = 6;
  localparam int NW = 1 << AW;
  localparam logic [15:0] MODE_IO = 16'hFF0F;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN;
  logic          memEn, memWe, ioEn, ioWe;
  logic [AW-1:0] memAddr;
  logic [15:0]   memWData, memRData, ioAddr;

  nvs_front #(.ADDR_W(AW), .MODE_IO_ADDR(MODE_IO)) i_nvs_front (
    .clk(clk), .rstN(rstN), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWData(memWData), .memRData(memRData), .ioEn(ioEn), .ioWe(ioWe),
    .ioAddr(ioAddr)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [15:0] model [NW];
  logic [15:0] rd;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ioOp(bit we, logic [15:0] a);
    ioEn = 1'b1; ioWe = we; ioAddr = a;
    @(negedge clk);
    ioEn = 1'b0; ioWe = 1'b0;
  endtask

  task automatic memWr(int a, logic [15:0] d);
    memEn = 1'b1; memWe = 1'b1; memAddr = AW'(a); memWData = d;
    @(negedge clk);
    memEn = 1'b0; memWe = 1'b0;
  endtask

  task automatic memRd(int a, output logic [15:0] d);
    memEn = 1'b1; memWe = 1'b0; memAddr = AW'(a);
    @(negedge clk);
    memEn = 1'b0;
    d = memRData;
  endtask

  function automatic logic [15:0] pat1(int a);
    return 16'hFFFF ^ (16'(a) * 16'h0407);
  endfunction

  function automatic logic [15:0] pat2(int a);
    return ~(16'h8001 << (a % 15)) | 16'h0F00;
  endfunction

  task automatic sweepArray(string req);
    for (int a = 0; a < NW; a++) begin
      memRd(a, rd);
      check(req, rd, model[a]);
    end
  endtask

  task automatic programPass(bit usePat2);
    for (int a = 0; a < NW; a++) begin
      logic [15:0] d;
      d = usePat2 ? pat2(a) : pat1(a);
      memWr(1, 16'(a));
      memWr(2, d);
      memWr(0, 16'h0002);
      model[a] = model[a] & d;
      if (a == 0) begin
        memRd(3, rd); check("R6 busy in cycle after program", rd, 16'h0001);
        memRd(3, rd); check("R6 idle one cycle later", rd, 16'h0000);
      end
    end
  endtask

  initial begin
    rstN = 1'b0; memEn = 0; memWe = 0; memAddr = '0; memWData = '0;
    ioEn = 0; ioWe = 0; ioAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 read data after reset", memRData, 16'h0000);

    // R2 enter register view, R1 registers cleared
    ioOp(1'b1, MODE_IO);
    for (int r = 0; r < 4; r++) begin
      memRd(r, rd); check("R1 register reset value", rd, 16'h0000);
    end

    // R5 erase with an ignored program command during busy (R7)
    memWr(1, 16'd5);
    memWr(2, 16'h0000);
    memWr(0, 16'h0001);
    memWr(0, 16'h0002);
    begin
      int busyCnt = 0;
      for (int i = 0; i < NW + 5; i++) begin
        memRd(3, rd); busyCnt += int'(rd[0]);
      end
      check("R5/R7 busy cycles after erase", 16'(busyCnt), 16'(NW - 1));
    end
    memRd(0, rd); check("R5 command self-cleared", rd, 16'h0000);
    for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;

    // R3 back to array view, R8 back-to-back sweep
    ioOp(1'b0, MODE_IO);
    sweepArray("R5/R8 erased array");
    memRd(5, rd); check("R7 ignored program left word 5", rd, 16'hFFFF);

    // R6 two program passes
    ioOp(1'b1, MODE_IO);
    programPass(1'b0);
    programPass(1'b1);
    ioOp(1'b0, MODE_IO);
    sweepArray("R6 programmed array");

    // R9 array-view write ignored
    memWr(7, ~model[7]);
    memRd(7, rd); check("R9 array write ignored", rd, model[7]);

    // R2 other I/O address has no effect
    ioOp(1'b1, 16'hFF0E);
    memRd(9, rd); check("R2 other I/O write keeps array view", rd, model[9]);

    // R4 aliasing across the window
    ioOp(1'b1, MODE_IO);
    for (int k = 0; k < NW / 4; k++) begin
      memWr(4 * k + 1, 16'h1111 * 16'(k));
      memRd(4 * (NW / 4 - 1 - k) + 1, rd);
      check("R4 target register alias", rd, 16'h1111 * 16'(k));
      memWr(4 * k + 2, 16'hA5A5 ^ 16'(k));
      memRd(4 * ((k + 3) % (NW / 4)) + 2, rd);
      check("R4 data register alias", rd, 16'hA5A5 ^ 16'(k));
      memRd(4 * k, rd);
      check("R4 command read hides array", rd, 16'h0000);
    end
    // R3 other I/O read does not leave register view
    ioOp(1'b0, 16'hFF0E);
    memRd(1, rd); check("R3 other I/O read keeps register view", rd, 16'h1111 * 16'(NW / 4 - 1));
    // R10 status write ignored, upper command bits read zero
    memWr(3, 16'hFFFF);
    memRd(3, rd); check("R10 status write ignored", rd, 16'h0000);
    memWr(0, 16'hFFFC);
    memRd(0, rd); check("R10 command upper bits zero", rd, 16'h0000);
    ioOp(1'b0, MODE_IO);
    sweepArray("R4 register writes left array intact");

    // R7 busy array read, R5 erase priority with both bits set
    ioOp(1'b1, MODE_IO);
    memWr(0, 16'h0003);
    ioOp(1'b0, MODE_IO);
    memRd(2, rd); check("R7 array read while busy", rd, 16'hFFFF);
    repeat (NW + 4) @(negedge clk);
    for (int a = 0; a < NW; a++) model[a] = 16'hFFFF;
    sweepArray("R5 erase priority over program");
    ioOp(1'b1, MODE_IO);
    memRd(0, rd); check("R5 command cleared after priority erase", rd, 16'h0000);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule